// File: doc/BRIEF.md
# Eight-Level Interrupt Priority Resolver

This block collects eight interrupt request lines that arrive from peripherals with no timing relation to the local clock. It keeps three 8-bit registers: requests waiting for service, a per-line mask, and lines now being serviced. Among the unmasked waiting requests it picks a winner. The processor interrupt output is raised only when that winner outranks every line already in service, so a nested interrupt can pre-empt a lower one but never an equal or higher one.

Software programs the block through a small register write port. One register selects edge or level triggering and fixed or rotating priority. One register holds the mask. One command register issues a non-specific end-of-interrupt. The processor answers an interrupt with a one-cycle acknowledge pulse. The number of the line being offered is always visible on a vector output. Mode and mask writes take effect at once, while requests and in-service lines are outstanding, and need no re-initialisation.

Top module: `irq_prio_resolver`

## Requirements
- R1: Each request line passes through two synchroniser flops and then the pending register, so a change on `irqIn` can reach `intOut` no earlier than the third rising clock edge after it is applied.
- R2: In fixed priority mode (config bit 1 = 0), line 0 ranks highest and line 7 lowest, and `vecOut` gives the index of the highest-ranked unmasked pending line.
- R3: Writing address 1 loads the mask, where bit i = 1 masks line i. A masked line keeps its pending bit but cannot raise `intOut`. Clearing the mask bit makes the held request visible again at once.
- R4: `intOut` is high only when some unmasked request is pending and its rank is strictly higher than the highest-ranked in-service line. A request of equal or lower rank leaves `intOut` low.
- R5: An `intAck` pulse while `intOut` is high sets the in-service bit of the line on `vecOut` and clears its pending bit in edge mode, and `intOut` then falls. An `intAck` while `intOut` is low changes nothing.
- R6: With config bit 0 = 0 (edge mode), one rising edge gives exactly one request, and a line held high after service does not request again. With config bit 0 = 1 (level mode), the pending bit follows the synchronised level, so a line that drops before acknowledge withdraws its request.
- R7: Writing address 2 with data bit 0 = 1 is a non-specific end-of-interrupt. It clears only the highest-ranked in-service bit under the current priority order. With no bit in service it changes nothing.
- R8: In rotating mode (config bit 1 = 1), the line cleared by an end-of-interrupt becomes the lowest rank, and the line numbered one above it (modulo 8) becomes the highest.
- R9: Config (address 0) may be rewritten while requests are pending or in service without losing them. Returning to fixed mode makes line 0 highest again.
- R10: After reset, the pending, in-service and mask registers are all zero, the block is in edge and fixed mode, and `intOut` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 8 | Asynchronous request lines, bit i = line i |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | 0 = config, 1 = mask, 2 = command, 3 = ignored |
| wrData | input | 8 | Write data |
| intAck | input | 1 | One-cycle acknowledge from the processor |
| intOut | output | 1 | Interrupt request to the processor |
| vecOut | output | 3 | Index of the winning unmasked pending line |
| pendOut | output | 8 | Pending request register |
| isrOut | output | 8 | In-service register |

## Verification
The bench aims at the in-service gate. A request of lower rank arrives while a higher one is in service, and a higher one arrives while a lower one is in service. A design that compares with greater-or-equal, or that ignores the in-service register, would raise `intOut` in the first case. A non-specific end-of-interrupt with two lines in service must clear the higher one, and a design that clears the lowest bit or all bits shows a wrong `isrOut`. In rotating mode, a pair of requests is chosen so that fixed and rotated order pick different winners, and the same is done after switching back to fixed mode. Masked and level-mode requests that are withdrawn check that nothing is lost or kept by mistake.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_CMD  = 2'd2;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic ack;
    logic eoi;
    logic cfgWr;
    logic maskWr;
  } ctrl_strobe_t;

endpackage

// File: rtl/irq_prio_pick.sv
// Finds the first set bit of vec, scanning from line base+1 upward with wrap.
module irq_prio_pick #(
  parameter int LINES = 8,
  localparam int IW = $clog2(LINES)
) (
  input  logic [LINES-1:0] vec,
  input  logic [IW-1:0]    base,
  output logic             valid,
  output logic [IW-1:0]    idx,
  output logic [IW-1:0]    rank
);

  function automatic logic [IW-1:0] rotIdx(input logic [IW-1:0] b, input int k);
    return IW'((int'(b) + 1 + k) % LINES);
  endfunction

  always_comb begin
    valid = 1'b0;
    idx   = '0;
    rank  = '0;
    for (int k = LINES - 1; k >= 0; k--) begin
      if (vec[rotIdx(base, k)]) begin
        valid = 1'b1;
        idx   = rotIdx(base, k);
        rank  = IW'(k);
      end
    end
  end

endmodule

// File: rtl/irq_prio_datapath.sv
module irq_prio_datapath
  import irq_prio_pkg::*;
#(
  parameter int LINES = 8,
  localparam int IW = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  irqIn,
  input  ctrl_strobe_t      stb,
  input  logic [LINES-1:0]  wrData,
  output logic              reqValid,
  output logic [IW-1:0]     reqIdx,
  output logic [IW-1:0]     reqRank,
  output logic              isrValid,
  output logic [IW-1:0]     isrRank,
  output logic [LINES-1:0]  pendOut,
  output logic [LINES-1:0]  isrOut
);

  logic [LINES-1:0] sync1, syncReq, syncPrev;
  logic [LINES-1:0] pend, isr, mask;
  logic [LINES-1:0] pendNext, isrNext, riseVec, reqVec;
  logic [LINES-1:0] ackHot, eoiHot;
  logic             cfgLevel, cfgRotate;
  logic [IW-1:0]    lowBase, effBase, isrIdx;

  assign effBase = cfgRotate ? lowBase : IW'(LINES - 1);
  assign reqVec  = pend & ~mask;
  assign riseVec = syncReq & ~syncPrev;
  assign ackHot  = stb.ack ? ({{(LINES-1){1'b0}}, 1'b1} << reqIdx) : '0;
  assign eoiHot  = (stb.eoi && isrValid) ? ({{(LINES-1){1'b0}}, 1'b1} << isrIdx) : '0;

  irq_prio_pick #(.LINES(LINES)) u_reqPick (
    .vec(reqVec), .base(effBase), .valid(reqValid), .idx(reqIdx), .rank(reqRank)
  );

  irq_prio_pick #(.LINES(LINES)) u_isrPick (
    .vec(isr), .base(effBase), .valid(isrValid), .idx(isrIdx), .rank(isrRank)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign pendNext[i] = cfgLevel ? syncReq[i]
                                  : (riseVec[i] | (pend[i] & ~ackHot[i]));
    assign isrNext[i]  = ackHot[i] | (isr[i] & ~eoiHot[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync1     <= '0;
      syncReq   <= '0;
      syncPrev  <= '0;
      pend      <= '0;
      isr       <= '0;
      mask      <= '0;
      cfgLevel  <= 1'b0;
      cfgRotate <= 1'b0;
      lowBase   <= IW'(LINES - 1);
    end else begin
      sync1    <= irqIn;
      syncReq  <= sync1;
      syncPrev <= syncReq;
      pend     <= pendNext;
      isr      <= isrNext;
      if (stb.maskWr) mask <= wrData;
      if (stb.cfgWr) begin
        cfgLevel  <= wrData[0];
        cfgRotate <= wrData[1];
      end
      if (stb.eoi && isrValid && cfgRotate) lowBase <= isrIdx;
    end
  end

  assign pendOut = pend;
  assign isrOut  = isr;

  // R5: an acknowledge puts the offered line in service
  assert_ack_sets_isr_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.ack |=> isr[$past(reqIdx)]);

  // R5: no line enters service without an acknowledge
  assert_no_isr_without_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ack |=> ((isr & ~$past(isr)) == '0));

  // R7: end-of-interrupt removes exactly one in-service line
  assert_eoi_one_bit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eoi && !stb.ack && (isr != '0)) |=> ($countones(isr) == $countones($past(isr)) - 1));

  // R7: end-of-interrupt with nothing in service is harmless
  assert_eoi_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eoi && !stb.ack && (isr == '0)) |=> (isr == '0));

  // R8: rotation makes the cleared line the lowest rank
  assert_rotate_base_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eoi && isrValid && cfgRotate) |=> (lowBase == $past(isrIdx)));

  // R6: a synchronised rising edge is always captured in edge mode
  assert_edge_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgLevel && (riseVec != '0)) |=> ((pend & $past(riseVec)) == $past(riseVec)));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int LINES = 8,
  localparam int IW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [1:0]    wrAddr,
  input  logic          cmdEoi,
  input  logic          intAck,
  input  logic          reqValid,
  input  logic [IW-1:0] reqRank,
  input  logic          isrValid,
  input  logic [IW-1:0] isrRank,
  output ctrl_strobe_t  stb,
  output logic          intOut
);

  // lower rank number means higher priority
  assign intOut = reqValid && (!isrValid || (reqRank < isrRank));

  always_comb begin
    stb        = '0;
    stb.ack    = intAck && intOut;
    stb.cfgWr  = wrEn && (wrAddr == ADDR_CFG);
    stb.maskWr = wrEn && (wrAddr == ADDR_MASK);
    stb.eoi    = wrEn && (wrAddr == ADDR_CMD) && cmdEoi;
  end

  // R4: interrupt output drops right after an accepted acknowledge
  assert_int_falls_after_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && !stb.maskWr && !stb.cfgWr && !stb.eoi) |=> !intOut || $changed(reqRank) || !$stable(isrRank));

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_prio_pkg::*;
#(
  parameter int LINES = 8,
  localparam int IW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] irqIn,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [LINES-1:0] wrData,
  input  logic             intAck,
  output logic             intOut,
  output logic [IW-1:0]    vecOut,
  output logic [LINES-1:0] pendOut,
  output logic [LINES-1:0] isrOut
);

  ctrl_strobe_t  stb;
  logic          reqValid, isrValid;
  logic [IW-1:0] reqIdx, reqRank, isrRank;

  irq_prio_ctrl #(.LINES(LINES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .cmdEoi(wrData[0]),
    .intAck(intAck), .reqValid(reqValid), .reqRank(reqRank),
    .isrValid(isrValid), .isrRank(isrRank), .stb(stb), .intOut(intOut)
  );

  irq_prio_datapath #(.LINES(LINES)) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .stb(stb), .wrData(wrData),
    .reqValid(reqValid), .reqIdx(reqIdx), .reqRank(reqRank),
    .isrValid(isrValid), .isrRank(isrRank), .pendOut(pendOut), .isrOut(isrOut)
  );

  assign vecOut = reqIdx;

endmodule

// File: tb/irq_prio_resolver_tb.sv
module irq_prio_resolver_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       intAck = 1'b0;
  logic       intOut;
  logic [2:0] vecOut;
  logic [7:0] pendOut, isrOut;

  int checks = 0;
  int failures = 0;

  irq_prio_resolver u_dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .intAck(intAck), .intOut(intOut), .vecOut(vecOut),
    .pendOut(pendOut), .isrOut(isrOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setIrq(input logic [7:0] v);
    irqIn = v;
    tick(3);
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick(1);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic ack();
    intAck = 1'b1;
    tick(1);
    intAck = 1'b0;
  endtask

  task automatic eoi();
    wrReg(2'd2, 8'h01);
  endtask

  task automatic testReset();
    chk("R10 intOut", int'(intOut), 0);
    chk("R10 pendOut", int'(pendOut), 0);
    chk("R10 isrOut", int'(isrOut), 0);
  endtask

  task automatic testSyncLatency();
    irqIn = 8'b0000_0100;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R1 not before third edge", int'(intOut), 0);
    tick(1);
    chk("R1 on third edge", int'(intOut), 1);
    chk("R1 vector", int'(vecOut), 2);
    ack();
    chk("R5 isr after ack", int'(isrOut), 8'h04);
    chk("R5 pend cleared", int'(pendOut), 0);
    chk("R5 intOut released", int'(intOut), 0);
    eoi();
    chk("R7 isr cleared", int'(isrOut), 0);
    setIrq(8'h00);
  endtask

  task automatic testFixedNesting();
    setIrq(8'b1010_0000);
    chk("R2 winner 5", int'(vecOut), 5);
    setIrq(8'b1010_1000);
    chk("R2 winner 3", int'(vecOut), 3);
    ack();
    chk("R5 isr line 3", int'(isrOut), 8'h08);
    chk("R4 lower blocked", int'(intOut), 0);
    eoi();
    chk("R4 released after eoi", int'(intOut), 1);
    chk("R2 winner 5 again", int'(vecOut), 5);
    ack();
    chk("R4 line 7 blocked by 5", int'(intOut), 0);
    setIrq(8'b1010_1010);
    chk("R4 higher pre-empts", int'(intOut), 1);
    chk("R2 winner 1", int'(vecOut), 1);
    ack();
    chk("R5 nested isr", int'(isrOut), 8'h22);
    eoi();
    chk("R7 clears highest only", int'(isrOut), 8'h20);
    chk("R4 still blocked", int'(intOut), 0);
    eoi();
    chk("R2 winner 7", int'(vecOut), 7);
    chk("R4 7 now offered", int'(intOut), 1);
    ack();
    eoi();
    eoi();
    chk("R7 empty eoi isr", int'(isrOut), 0);
    chk("R7 empty eoi pend", int'(pendOut), 0);
    setIrq(8'h00);
  endtask

  task automatic testMask();
    wrReg(2'd1, 8'h01);
    setIrq(8'h01);
    chk("R3 masked no int", int'(intOut), 0);
    chk("R3 pending kept", int'(pendOut), 1);
    ack();
    chk("R5 stray ack isr", int'(isrOut), 0);
    chk("R5 stray ack pend", int'(pendOut), 1);
    wrReg(2'd1, 8'h00);
    chk("R3 unmask int", int'(intOut), 1);
    chk("R3 unmask vec", int'(vecOut), 0);
    ack();
    eoi();
    setIrq(8'h00);
  endtask

  task automatic testTrigger();
    setIrq(8'h10);
    chk("R6 edge int", int'(intOut), 1);
    ack();
    eoi();
    tick(3);
    chk("R6 held line no repeat", int'(intOut), 0);
    chk("R6 held line pend", int'(pendOut), 0);
    wrReg(2'd0, 8'h01);
    tick(1);
    chk("R6 level pend", int'(pendOut), 8'h10);
    chk("R6 level int", int'(intOut), 1);
    setIrq(8'h00);
    chk("R6 level withdrawn pend", int'(pendOut), 0);
    chk("R6 level withdrawn int", int'(intOut), 0);
    wrReg(2'd0, 8'h00);
  endtask

  task automatic testRotate();
    wrReg(2'd0, 8'h02);
    setIrq(8'b0000_1000);
    chk("R8 first vec", int'(vecOut), 3);
    ack();
    eoi();
    setIrq(8'b0010_0100);
    chk("R8 rotated winner 5", int'(vecOut), 5);
    ack();
    chk("R4 rotated block", int'(intOut), 0);
    eoi();
    chk("R8 line 2 offered", int'(intOut), 1);
    chk("R8 vec 2", int'(vecOut), 2);
    ack();
    eoi();
    setIrq(8'b0100_0010);
    chk("R8 rotated winner 6", int'(vecOut), 6);
    wrReg(2'd0, 8'h00);
    chk("R9 fixed winner 1", int'(vecOut), 1);
    chk("R9 pend kept", int'(pendOut), 8'h42);
    ack();
    chk("R9 line 6 blocked", int'(intOut), 0);
    eoi();
    chk("R9 line 6 offered", int'(vecOut), 6);
    ack();
    eoi();
    chk("R9 all clear", int'(isrOut), 0);
    setIrq(8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    testReset();
    testSyncLatency();
    testFixedNesting();
    testMask();
    testTrigger();
    testRotate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule